// File: doc/BRIEF.md
# Circular, Bit-Reversed and Post-Increment Address Generator

This block produces data-memory addresses for signal-processing loops. It has three stepping modes. Circular mode keeps a ring of K entries at a base address. Each step returns the slot holding the oldest entry, which is the slot where a new sample is written, and then advances that slot index with wraparound. No stored data is ever moved. Bit-reversed mode walks a counter of b bits and reverses its bits, which gives the reordering that radix-2 FFT passes need. Post-increment mode returns a running pointer and then moves it by a signed offset scaled by the element size.

Software-visible state is loaded through three load strobes: base, length (with the bit-reverse width) and offset (with the element-size scale). A step strobe advances the generator by one access. The address output is registered. It changes only on the cycle after an accepted step. All address arithmetic is 32 bits wide and wraps modulo 2^32. The index counter is shared by the circular and bit-reversed modes. The memory itself lies outside the block.

Top module: `dsp_addr_gen`

## Requirements
- R1: While reset is asserted (synchronous, active low), the address output, index, pointer, base, length, bit width, offset and scale all clear to zero.
- R2: The address output changes only one clock after a cycle in which step is high and neither base_load nor len_load is high. In every other cycle it holds its value.
- R3: With mode_sel = 2'b00 (circular), a step outputs base + (index << scale) and then advances the index by one. When the index reaches length−1 it wraps to 0. A length of 0 keeps the index at 0.
- R4: The circular length need not be a power of two. With length 5, successive steps visit slots 0,1,2,3,4,0,1.
- R5: With mode_sel = 2'b01 (bit-reversed), a step outputs base + (rev_b(index) << scale). Here rev_b mirrors the low b bits of the index, and b is the width loaded with the length, clamped to 12. The index then advances modulo 2^b, so b = 0 always yields the base.
- R6: With mode_sel = 2'b10 (post-increment), a step outputs the current pointer. The pointer then advances by the signed 32-bit offset shifted left by scale, where scale 0..3 means elements of 1, 2, 4 or 8 bytes. The sum wraps modulo 2^32.
- R7: A base or length load clears the index to 0 and sets the pointer to the base in force after the load, both on the next cycle. A step in the same cycle is ignored.
- R8: An offset load changes only the offset and scale. The index and the pointer keep their values.
- R9: With mode_sel = 2'b11 (frozen), a step leaves the address output, index and pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | 00 circular, 01 bit-reversed, 10 post-increment, 11 frozen |
| step | input | 1 | Advance by one access |
| base_load | input | 1 | Load base register |
| base_in | input | 32 | New base address |
| len_load | input | 1 | Load length and bit-reverse width |
| len_in | input | 16 | Circular length K |
| brev_bits_in | input | 4 | Bit-reverse width b (clamped to 12) |
| ofs_load | input | 1 | Load offset and scale |
| ofs_in | input | 32 | Signed post-increment offset |
| scale_in | input | 2 | Element-size shift, 0..3 |
| addr_out | output | 32 | Registered address |

## Verification
A wrong index shows up at the port on the very next accepted step, as an address off by a multiple of the element size. Two kinds of index fault appear only once the sequence reaches their point: a wrap placed at the wrong slot shows within K steps, and a wrong bit mirror shows within 2^b steps. Sequences therefore run past a full wrap in both modes, using a length that is not a power of two. A stale pointer or an index that is not cleared shows on the first step after a load. Separate checks confirm that loads, offset updates and the frozen mode leave the index and pointer intact, by stepping again afterwards.

// File: rtl/agen_pkg.sv
// Shared types for the address generator.
package agen_pkg;
    typedef enum logic [1:0] {
        AG_CIRC   = 2'b00,
        AG_BREV   = 2'b01,
        AG_POST   = 2'b10,
        AG_FREEZE = 2'b11
    } agen_mode_e;
endpackage

// File: rtl/agen_cfg_regs.sv
// Configuration registers: base, length, bit-reverse width, offset, scale.
// Assumes MAXB fits in BITS_W bits. Produces a restart pulse on any
// base or length load, plus the base value that will be in force afterwards.
module agen_cfg_regs #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16,
    parameter int MAXB   = 12,
    parameter int BITS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_load,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              len_load,
    input  logic [IDX_W-1:0]  len_in,
    input  logic [BITS_W-1:0] bits_in,
    input  logic              ofs_load,
    input  logic [ADDR_W-1:0] ofs_in,
    input  logic [1:0]        scale_in,
    output logic [ADDR_W-1:0] base_q,
    output logic [IDX_W-1:0]  len_q,
    output logic [BITS_W-1:0] bits_q,
    output logic [ADDR_W-1:0] ofs_q,
    output logic [1:0]        scale_q,
    output logic              restart,
    output logic [ADDR_W-1:0] restart_base
);
    localparam logic [BITS_W-1:0] MAXB_V = BITS_W'(MAXB);

    // Restart request and the base that the pointer reloads from.
    always_comb begin
        restart      = base_load | len_load;
        restart_base = base_load ? base_in : base_q;
    end

    // Base register.
    always_ff @(posedge clk) begin
        if (!rst_n)         base_q <= '0;
        else if (base_load) base_q <= base_in;
    end

    // Length and clamped bit-reverse width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            bits_q <= '0;
        end else if (len_load) begin
            len_q  <= len_in;
            bits_q <= (bits_in > MAXB_V) ? MAXB_V : bits_in;
        end
    end

    // Offset and element-size scale.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q   <= '0;
            scale_q <= '0;
        end else if (ofs_load) begin
            ofs_q   <= ofs_in;
            scale_q <= scale_in;
        end
    end
endmodule

// File: rtl/agen_bitrev.sv
// Mirrors the low `bits` bits of an index. Assumes bits <= MAXB <= IDX_W.
// The full MAXB-bit reversal is shifted right so that only b bits remain.
module agen_bitrev #(
    parameter int IDX_W  = 16,
    parameter int MAXB   = 12,
    parameter int BITS_W = 4
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [BITS_W-1:0] bits,
    output logic [IDX_W-1:0]  rev
);
    localparam logic [BITS_W-1:0] MAXB_V = BITS_W'(MAXB);

    logic [MAXB-1:0]   full;
    logic [BITS_W-1:0] sh;

    for (genvar g = 0; g < MAXB; g++) begin : g_mirror
        assign full[g] = idx[MAXB-1-g];
    end

    // Drop the reversed bits that lie above the chosen width.
    always_comb begin
        sh  = MAXB_V - bits;
        rev = IDX_W'(full >> sh);
    end
endmodule

// File: rtl/agen_index.sv
// Shared slot counter. Circular mode wraps at length-1 (any length);
// bit-reversed mode wraps modulo 2^bits. Assumes bits <= IDX_W.
module agen_index #(
    parameter int IDX_W  = 16,
    parameter int BITS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    input  logic [1:0]        mode,
    input  logic [IDX_W-1:0]  len,
    input  logic [BITS_W-1:0] bits,
    output logic [IDX_W-1:0]  idx_q
);
    import agen_pkg::*;

    logic [IDX_W:0]   inc;
    logic [IDX_W:0]   pow;
    logic [IDX_W-1:0] nxt;

    // Next index for the active mode.
    always_comb begin
        inc = {1'b0, idx_q} + 1'b1;
        pow = {{IDX_W{1'b0}}, 1'b1} << bits;
        unique case (agen_mode_e'(mode))
            AG_CIRC: nxt = (inc >= {1'b0, len}) ? '0 : inc[IDX_W-1:0];
            AG_BREV: nxt = inc[IDX_W-1:0] & IDX_W'(pow - 1'b1);
            default: nxt = idx_q;
        endcase
    end

    // Index register; a restart has priority over a step.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) idx_q <= '0;
        else if (advance)      idx_q <= nxt;
    end
endmodule

// File: rtl/agen_ptr.sv
// Post-increment pointer: moves by offset << scale on each accepted step,
// reloads from the base on restart. Wraps modulo 2^ADDR_W.
module agen_ptr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [ADDR_W-1:0] restart_base,
    input  logic              advance,
    input  logic [ADDR_W-1:0] ofs,
    input  logic [1:0]        scale,
    output logic [ADDR_W-1:0] ptr_q
);
    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= '0;
        else if (restart) ptr_q <= restart_base;
        else if (advance) ptr_q <= ptr_q + (ofs << scale);
    end
endmodule

// File: rtl/dsp_addr_gen.sv
// Address generator top. Combines the configuration registers, the shared
// index, the bit mirror and the pointer. Drives a registered address that
// updates only on accepted steps. Assumes ADDR_W >= IDX_W >= MAXB.
module dsp_addr_gen
    import agen_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16,
    parameter int MAXB   = 12,
    localparam int BITS_W = $clog2(MAXB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              step,
    input  logic              base_load,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              len_load,
    input  logic [IDX_W-1:0]  len_in,
    input  logic [BITS_W-1:0] brev_bits_in,
    input  logic              ofs_load,
    input  logic [ADDR_W-1:0] ofs_in,
    input  logic [1:0]        scale_in,
    output logic [ADDR_W-1:0] addr_out
);
    logic [ADDR_W-1:0] base_q, ofs_q, restart_base, ptr_q;
    logic [IDX_W-1:0]  len_q, idx_q, rev_idx;
    logic [BITS_W-1:0] bits_q;
    logic [1:0]        scale_q;
    logic              restart, take, ptr_adv;
    logic [ADDR_W-1:0] circ_addr, brev_addr;

    agen_cfg_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .MAXB(MAXB), .BITS_W(BITS_W)) i_cfg (
        .clk(clk), .rst_n(rst_n),
        .base_load(base_load), .base_in(base_in),
        .len_load(len_load), .len_in(len_in), .bits_in(brev_bits_in),
        .ofs_load(ofs_load), .ofs_in(ofs_in), .scale_in(scale_in),
        .base_q(base_q), .len_q(len_q), .bits_q(bits_q),
        .ofs_q(ofs_q), .scale_q(scale_q),
        .restart(restart), .restart_base(restart_base)
    );

    agen_index #(.IDX_W(IDX_W), .BITS_W(BITS_W)) i_idx (
        .clk(clk), .rst_n(rst_n), .restart(restart), .advance(take),
        .mode(mode_sel), .len(len_q), .bits(bits_q), .idx_q(idx_q)
    );

    agen_bitrev #(.IDX_W(IDX_W), .MAXB(MAXB), .BITS_W(BITS_W)) i_rev (
        .idx(idx_q), .bits(bits_q), .rev(rev_idx)
    );

    agen_ptr #(.ADDR_W(ADDR_W)) i_ptr (
        .clk(clk), .rst_n(rst_n), .restart(restart), .restart_base(restart_base),
        .advance(ptr_adv), .ofs(ofs_q), .scale(scale_q), .ptr_q(ptr_q)
    );

    // Step acceptance and per-mode candidate addresses.
    always_comb begin
        take      = step & ~restart;
        ptr_adv   = take & (agen_mode_e'(mode_sel) == AG_POST);
        circ_addr = base_q + (ADDR_W'(idx_q) << scale_q);
        brev_addr = base_q + (ADDR_W'(rev_idx) << scale_q);
    end

    // Registered address output, updated only on an accepted step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out <= '0;
        end else if (take) begin
            unique case (agen_mode_e'(mode_sel))
                AG_CIRC:   addr_out <= circ_addr;
                AG_BREV:   addr_out <= brev_addr;
                AG_POST:   addr_out <= ptr_q;
                AG_FREEZE: addr_out <= addr_out;
            endcase
        end
    end
endmodule

// File: rtl/agen_checker.sv
// Temporal checks on the address generator, bound to every instance.
module agen_checker #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_sel,
    input logic              step,
    input logic              base_load,
    input logic              len_load,
    input logic [ADDR_W-1:0] addr_out,
    input logic [IDX_W-1:0]  idx_q,
    input logic [IDX_W-1:0]  len_q,
    input logic [ADDR_W-1:0] ptr_q
);
    logic ld;
    assign ld = base_load | len_load;

    // R1: reset clears the output and the index.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (addr_out == '0 && idx_q == '0));

    // R2: no accepted step, no output change.
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step || ld) |=> $stable(addr_out));

    // R3: circular index wraps to zero after the last slot.
    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00 && step && !ld && len_q != '0 && idx_q == len_q - 1'b1)
        |=> idx_q == '0);

    // R6: post-increment returns the pointer held before the step.
    assert_post_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b10 && step && !ld) |=> addr_out == $past(ptr_q));

    // R7: a base or length load clears the index.
    assert_load_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> idx_q == '0);

    // R9: frozen mode keeps index and pointer.
    assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11 && !ld) |=> ($stable(idx_q) && $stable(ptr_q)));
endmodule

bind dsp_addr_gen agen_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_agen_checker (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .step(step),
    .base_load(base_load), .len_load(len_load), .addr_out(addr_out),
    .idx_q(idx_q), .len_q(len_q), .ptr_q(ptr_q)
);

// File: tb/test_dsp_addr_gen.sv
`timescale 1ns/1ps
module test_dsp_addr_gen;
    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode_sel;
    logic        step, base_load, len_load, ofs_load;
    logic [31:0] base_in, ofs_in;
    logic [15:0] len_in;
    logic [3:0]  brev_bits_in;
    logic [1:0]  scale_in;
    logic [31:0] addr_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(HALF) clk = ~clk;

    dsp_addr_gen i_dsp_addr_gen (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .step(step),
        .base_load(base_load), .base_in(base_in),
        .len_load(len_load), .len_in(len_in), .brev_bits_in(brev_bits_in),
        .ofs_load(ofs_load), .ofs_in(ofs_in), .scale_in(scale_in),
        .addr_out(addr_out)
    );

    // Rows: {mode[1:0], step, expected address}. Setup: base 0x1000,
    // length 5, 3 reverse bits, offset 3, scale 2 (4-byte elements).
    localparam int NV = 20;
    localparam logic [34:0] VEC [NV] = '{
        {2'b00, 1'b1, 32'h1000}, {2'b00, 1'b1, 32'h1004}, {2'b00, 1'b1, 32'h1008},
        {2'b00, 1'b1, 32'h100C}, {2'b00, 1'b1, 32'h1010}, {2'b00, 1'b1, 32'h1000},
        {2'b00, 1'b1, 32'h1004},
        {2'b00, 1'b0, 32'h1004},
        {2'b11, 1'b1, 32'h1004},
        {2'b01, 1'b1, 32'h1008}, {2'b01, 1'b1, 32'h1018}, {2'b01, 1'b1, 32'h1004},
        {2'b01, 1'b1, 32'h1014}, {2'b01, 1'b1, 32'h100C}, {2'b01, 1'b1, 32'h101C},
        {2'b01, 1'b1, 32'h1000},
        {2'b00, 1'b1, 32'h1004},
        {2'b10, 1'b1, 32'h1000}, {2'b10, 1'b1, 32'h100C}, {2'b10, 1'b1, 32'h1018}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        step = 1'b0; base_load = 1'b0; len_load = 1'b0; ofs_load = 1'b0;
    endtask

    task automatic do_step(input logic [1:0] m, input logic [31:0] exp, input string req);
        mode_sel = m; step = 1'b1;
        tick();
        idle();
        check(req, addr_out, exp);
    endtask

    function automatic string row_req(input logic [1:0] m, input logic s);
        if (!s)          return "R2 hold";
        if (m == 2'b00)  return "R3 R4 circular";
        if (m == 2'b01)  return "R5 bit-reversed";
        if (m == 2'b10)  return "R6 post-increment";
        return "R9 frozen";
    endfunction

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(HALF * 2 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode_sel = 2'b00; idle();
        base_in = '0; ofs_in = '0; len_in = '0; brev_bits_in = '0; scale_in = '0;
        tick(); tick();
        check("R1 reset", addr_out, 32'h0);
        rst_n = 1'b1;

        // Configuration with no step: output holds.
        base_load = 1'b1; base_in = 32'h1000;
        len_load  = 1'b1; len_in  = 16'd5; brev_bits_in = 4'd3;
        ofs_load  = 1'b1; ofs_in  = 32'd3; scale_in = 2'd2;
        tick(); idle();
        check("R2 load without step", addr_out, 32'h0);

        for (int i = 0; i < NV; i++) begin
            mode_sel = VEC[i][34:33];
            step     = VEC[i][32];
            tick(); idle();
            check(row_req(VEC[i][34:33], VEC[i][32]), addr_out, VEC[i][31:0]);
        end

        // R7: circular step, then a length load with a step in the same cycle.
        do_step(2'b00, 32'h1008, "R3 circular continue");
        len_load = 1'b1; len_in = 16'd5; brev_bits_in = 4'd3; mode_sel = 2'b00; step = 1'b1;
        tick(); idle();
        check("R7 step ignored during load", addr_out, 32'h1008);
        do_step(2'b00, 32'h1000, "R7 index cleared");
        do_step(2'b10, 32'h1000, "R7 pointer reloaded");

        // R8: offset load leaves pointer and index alone.
        ofs_load = 1'b1; ofs_in = 32'd1; scale_in = 2'd0;
        tick(); idle();
        check("R8 offset load holds output", addr_out, 32'h1000);
        do_step(2'b10, 32'h100C, "R8 pointer kept");
        do_step(2'b10, 32'h100D, "R8 new offset");
        do_step(2'b00, 32'h1001, "R8 index kept");

        // R6: negative offset with 8-byte elements wraps below zero.
        base_load = 1'b1; base_in = 32'h4;
        ofs_load  = 1'b1; ofs_in  = 32'hFFFF_FFFF; scale_in = 2'd3;
        tick(); idle();
        do_step(2'b10, 32'h0000_0004, "R6 first");
        do_step(2'b10, 32'hFFFF_FFFC, "R6 wrap");
        do_step(2'b10, 32'hFFFF_FFF4, "R6 second");

        // R3/R5 degenerate sizes: length 0 and zero reverse bits stay at base.
        len_load = 1'b1; len_in = 16'd0; brev_bits_in = 4'd0;
        tick(); idle();
        do_step(2'b00, 32'h4, "R3 length zero");
        do_step(2'b00, 32'h4, "R3 length zero again");
        do_step(2'b01, 32'h4, "R5 zero bits");

        // R1: reset in mid-run.
        rst_n = 1'b0;
        tick();
        check("R1 reset mid-run", addr_out, 32'h0);
        rst_n = 1'b1;
        do_step(2'b10, 32'h0, "R1 pointer cleared");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule